// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencer

This block is the Moore control sequencer of a processor datapath that shares one memory and one ALU across several clock cycles of each instruction. It watches the 6-bit major opcode held in the instruction register. In every cycle it drives the selects and enables that steer the datapath: the memory address source, memory read and write, instruction register load, the register-file destination and write-back source, and write enable, both ALU operand selects, the ALU function request, and program counter update.

Every instruction starts with an instruction fetch and a decode step. It then takes a path that depends on its class. A load takes five cycles, a store or register-to-register ALU operation takes four, and a conditional equal-branch or an unconditional jump takes three. An opcode the sequencer does not know sends it back to fetch right after decode. The separate ALU function decoder sits beside this block and reads the funct field when the sequencer asks it to.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-low reset puts the sequencer in the fetch step. While reset is low, every output is 0. The first cycle after reset is released is a fetch cycle, and a reset in the middle of an instruction abandons that instruction.
- R2: Fetch drives mem_rd=1, instr_ld=1, alu_b_sel=01 (constant four), alu_func=00 (add), pc_we=1 and pc_sel=00 (ALU result). Every other output is 0. Fetch is always followed by decode.
- R3: Decode drives alu_b_sel=11 (shifted sign-extended offset), alu_a_sel=0 and alu_func=00, with every other output 0, so the branch target is formed while the operands are read.
- R4: Load (opcode 100011) runs fetch, decode, address (alu_a_sel=1, alu_b_sel=10), memory read (addr_sel_alu=1, mem_rd=1), write-back (wb_sel_mem=1, rf_we=1, dst_sel_rd=0), then fetch.
- R5: Store (opcode 101011) runs fetch, decode, address, memory write (addr_sel_alu=1, mem_wr=1), then fetch.
- R6: Register-type (opcode 000000) runs fetch, decode, execute (alu_a_sel=1, alu_b_sel=00, alu_func=10 meaning funct-defined), completion (dst_sel_rd=1, rf_we=1, wb_sel_mem=0), then fetch.
- R7: Equal-branch (opcode 000100) runs fetch, decode, compare (alu_a_sel=1, alu_b_sel=00, alu_func=01 subtract, pc_we_if_zero=1, pc_sel=01 stored target), then fetch. pc_we and pc_we_if_zero are never both 1.
- R8: Jump (opcode 000010) runs fetch, decode, then a cycle with pc_we=1 and pc_sel=10 (jump address), then fetch.
- R9: Any other opcode returns to fetch in the cycle after decode. No write enable is raised in that decode cycle.
- R10: The opcode is ignored outside decode and address. A change on it during fetch, execute, memory or completion cycles does not alter the sequence.
- R11: In every step not listed above, the selects and enables it does not name are 0. Memory read, memory write and register-file write are pairwise never 1 together, and no instruction lasts more than five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Major opcode from the instruction register |
| addr_sel_alu | output | 1 | Memory address from stored ALU result (1) or program counter (0) |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| instr_ld | output | 1 | Load instruction register from memory |
| dst_sel_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| rf_we | output | 1 | Register-file write enable |
| wb_sel_mem | output | 1 | Write-back data from memory data register (1) or ALU result register (0) |
| alu_a_sel | output | 1 | ALU operand A from register A (1) or program counter (0) |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 four, 10 offset, 11 offset times four |
| alu_func | output | 2 | ALU request: 00 add, 01 subtract, 10 funct field |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_if_zero | output | 1 | Program counter write when the ALU result is zero |
| pc_sel | output | 2 | PC source: 00 ALU, 01 stored ALU result, 10 jump address |

## Verification
The bench walks each instruction class cycle by cycle and compares the full output word in every step. A wrong transition, such as a store falling into write-back or a branch lingering a cycle, shows up as a mismatched word in a named step. It changes the opcode during cycles where it must be ignored. A sequencer that decodes in the wrong step would turn a register operation into a load or cut it short. A reset dropped in the middle of a load must silence every enable and restart at fetch, where a faulty design would either finish the load or leave a write enable high. An unknown opcode must leave decode for fetch without any write. A design that falls through into a class path would raise memory or register enables.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OP_W = 6;

    localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OP_W-1:0] OPC_REGOP  = 6'b000000;
    localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OP_W-1:0] OPC_JUMP   = 6'b000010;

    localparam logic [1:0] BSRC_REG   = 2'b00;
    localparam logic [1:0] BSRC_FOUR  = 2'b01;
    localparam logic [1:0] BSRC_IMM   = 2'b10;
    localparam logic [1:0] BSRC_IMMX4 = 2'b11;

    localparam logic [1:0] FN_ADD   = 2'b00;
    localparam logic [1:0] FN_SUB   = 2'b01;
    localparam logic [1:0] FN_FIELD = 2'b10;

    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_HELD = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_MRD,
        ST_LDWB,
        ST_MWR,
        ST_EXEC,
        ST_RDONE,
        ST_BRCMP,
        ST_JMP
    } state_e;

    typedef enum logic [2:0] {
        K_LOAD,
        K_STORE,
        K_REGOP,
        K_BRANCH,
        K_JUMP,
        K_OTHER
    } kind_e;

    typedef struct packed {
        logic       addr_sel_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       instr_ld;
        logic       dst_sel_rd;
        logic       rf_we;
        logic       wb_sel_mem;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_func;
        logic       pc_we;
        logic       pc_we_if_zero;
        logic [1:0] pc_sel;
    } ctrl_t;

endpackage

// File: rtl/mcc_op_class.sv
module mcc_op_class
    import mcc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output kind_e           kind
);

    always_comb begin
        unique case (opcode)
            OPC_LOAD:   kind = K_LOAD;
            OPC_STORE:  kind = K_STORE;
            OPC_REGOP:  kind = K_REGOP;
            OPC_BRANCH: kind = K_BRANCH;
            OPC_JUMP:   kind = K_JUMP;
            default:    kind = K_OTHER;
        endcase
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e state_q,
    input  kind_e  kind,
    output state_e state_d
);

    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (kind)
                    K_LOAD, K_STORE: state_d = ST_ADDR;
                    K_REGOP:         state_d = ST_EXEC;
                    K_BRANCH:        state_d = ST_BRCMP;
                    K_JUMP:          state_d = ST_JMP;
                    default:         state_d = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                if (kind == K_LOAD)       state_d = ST_MRD;
                else if (kind == K_STORE) state_d = ST_MWR;
                else                      state_d = ST_FETCH;
            end
            ST_MRD:   state_d = ST_LDWB;
            ST_EXEC:  state_d = ST_RDONE;
            ST_LDWB, ST_MWR, ST_RDONE, ST_BRCMP, ST_JMP: state_d = ST_FETCH;
            default:  state_d = ST_FETCH;
        endcase
    end

    // fetch always hands over to decode
    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH |-> state_d == ST_DECODE);

    // completing steps never chain into another non-fetch step
    p_tail_to_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LDWB || state_q == ST_MWR || state_q == ST_RDONE ||
         state_q == ST_BRCMP || state_q == ST_JMP) |-> state_d == ST_FETCH);

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  state_e state_q,
    output ctrl_t  ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.instr_ld  = 1'b1;
                ctrl.alu_b_sel = BSRC_FOUR;
                ctrl.alu_func  = FN_ADD;
                ctrl.pc_we     = 1'b1;
                ctrl.pc_sel    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = BSRC_IMMX4;
                ctrl.alu_func  = FN_ADD;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSRC_IMM;
                ctrl.alu_func  = FN_ADD;
            end
            ST_MRD: begin
                ctrl.addr_sel_alu = 1'b1;
                ctrl.mem_rd       = 1'b1;
            end
            ST_LDWB: begin
                ctrl.wb_sel_mem = 1'b1;
                ctrl.rf_we      = 1'b1;
            end
            ST_MWR: begin
                ctrl.addr_sel_alu = 1'b1;
                ctrl.mem_wr       = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = BSRC_REG;
                ctrl.alu_func  = FN_FIELD;
            end
            ST_RDONE: begin
                ctrl.dst_sel_rd = 1'b1;
                ctrl.rf_we      = 1'b1;
            end
            ST_BRCMP: begin
                ctrl.alu_a_sel     = 1'b1;
                ctrl.alu_b_sel     = BSRC_REG;
                ctrl.alu_func      = FN_SUB;
                ctrl.pc_we_if_zero = 1'b1;
                ctrl.pc_sel        = PCS_HELD;
            end
            ST_JMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_sel = PCS_JMP;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
    import mcc_pkg::*;
#(
    parameter int MAX_CYC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic            addr_sel_alu,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            instr_ld,
    output logic            dst_sel_rd,
    output logic            rf_we,
    output logic            wb_sel_mem,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_func,
    output logic            pc_we,
    output logic            pc_we_if_zero,
    output logic [1:0]      pc_sel
);

    localparam int PH_W = $clog2(MAX_CYC + 1);

    typedef struct packed {
        state_e          st;
        logic [PH_W-1:0] phase;
    } seq_t;

    seq_t   seq_d, seq_q;
    kind_e  kind;
    state_e st_next;
    ctrl_t  ctrl_raw, ctrl_out;

    mcc_op_class u_op_class (
        .opcode (opcode),
        .kind   (kind)
    );

    mcc_next_state u_next_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (seq_q.st),
        .kind    (kind),
        .state_d (st_next)
    );

    mcc_out_decode u_out_decode (
        .state_q (seq_q.st),
        .ctrl    (ctrl_raw)
    );

    always_comb begin
        seq_d.st    = st_next;
        seq_d.phase = (st_next == ST_FETCH) ? '0 : seq_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= ST_FETCH;
            seq_q.phase <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // reset holds every output quiet
    always_comb ctrl_out = rst_n ? ctrl_raw : '0;

    assign addr_sel_alu  = ctrl_out.addr_sel_alu;
    assign mem_rd        = ctrl_out.mem_rd;
    assign mem_wr        = ctrl_out.mem_wr;
    assign instr_ld      = ctrl_out.instr_ld;
    assign dst_sel_rd    = ctrl_out.dst_sel_rd;
    assign rf_we         = ctrl_out.rf_we;
    assign wb_sel_mem    = ctrl_out.wb_sel_mem;
    assign alu_a_sel     = ctrl_out.alu_a_sel;
    assign alu_b_sel     = ctrl_out.alu_b_sel;
    assign alu_func      = ctrl_out.alu_func;
    assign pc_we         = ctrl_out.pc_we;
    assign pc_we_if_zero = ctrl_out.pc_we_if_zero;
    assign pc_sel        = ctrl_out.pc_sel;

    // first cycle out of reset is a fetch
    p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (instr_ld && pc_we && mem_rd));

    // one memory access or one register write per cycle
    p_unit_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, rf_we}) <= 1);

    // a program counter write is either forced or conditional
    p_pc_write_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_we && pc_we_if_zero));

    // register write closes an instruction: next cycle fetches
    p_write_then_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> instr_ld);

    // instruction register loads once per instruction
    p_ir_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ld |=> !instr_ld);

    // memory read of a load is followed by its write-back
    p_load_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_sel_alu) |=> (rf_we && wb_sel_mem));

    // no instruction exceeds its cycle budget
    p_cycle_budget_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.phase <= PH_W'(MAX_CYC - 1));

endmodule

// File: tb/test_mcc_ctrl_fsm.sv
module test_mcc_ctrl_fsm;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] opcode;
    logic       addr_sel_alu, mem_rd, mem_wr, instr_ld, dst_sel_rd, rf_we;
    logic       wb_sel_mem, alu_a_sel, pc_we, pc_we_if_zero;
    logic [1:0] alu_b_sel, alu_func, pc_sel;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcc_ctrl_fsm i_mcc_ctrl_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .opcode        (opcode),
        .addr_sel_alu  (addr_sel_alu),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .instr_ld      (instr_ld),
        .dst_sel_rd    (dst_sel_rd),
        .rf_we         (rf_we),
        .wb_sel_mem    (wb_sel_mem),
        .alu_a_sel     (alu_a_sel),
        .alu_b_sel     (alu_b_sel),
        .alu_func      (alu_func),
        .pc_we         (pc_we),
        .pc_we_if_zero (pc_we_if_zero),
        .pc_sel        (pc_sel)
    );

    // packed order: aalu rd wr ir dst rfwe wbm asel bsel[2] fn[2] pcw pcz pcs[2]
    function automatic logic [15:0] ev(input logic aalu, rd, wr, ir, dst, rfwe, wbm, asel,
                                       input logic [1:0] bsel, fn,
                                       input logic pcw, pcz,
                                       input logic [1:0] pcs);
        return {aalu, rd, wr, ir, dst, rfwe, wbm, asel, bsel, fn, pcw, pcz, pcs};
    endfunction

    logic [15:0] e_zero, e_fetch, e_dec, e_addr, e_mrd, e_ldwb, e_mwr, e_exec, e_rdone, e_br, e_jmp;

    initial begin
        e_zero  = '0;
        e_fetch = ev(0,1,0,1,0,0,0,0,2'b01,2'b00,1,0,2'b00);
        e_dec   = ev(0,0,0,0,0,0,0,0,2'b11,2'b00,0,0,2'b00);
        e_addr  = ev(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0,2'b00);
        e_mrd   = ev(1,1,0,0,0,0,0,0,2'b00,2'b00,0,0,2'b00);
        e_ldwb  = ev(0,0,0,0,0,1,1,0,2'b00,2'b00,0,0,2'b00);
        e_mwr   = ev(1,0,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00);
        e_exec  = ev(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0,2'b00);
        e_rdone = ev(0,0,0,0,1,1,0,0,2'b00,2'b00,0,0,2'b00);
        e_br    = ev(0,0,0,0,0,0,0,1,2'b00,2'b01,0,1,2'b01);
        e_jmp   = ev(0,0,0,0,0,0,0,0,2'b00,2'b00,1,0,2'b10);
    end

    task automatic check(input logic [15:0] exp, input string tag);
        logic [15:0] got;
        #1;
        got = {addr_sel_alu, mem_rd, mem_wr, instr_ld, dst_sel_rd, rf_we, wb_sel_mem,
               alu_a_sel, alu_b_sel, alu_func, pc_we, pc_we_if_zero, pc_sel};
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step(input logic [15:0] exp, input string tag);
        check(exp, tag);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; opcode = 6'b100011;
        repeat (2) @(negedge clk);
        check(e_zero, "R1 outputs quiet in reset");
        @(negedge clk);
        rst_n = 1'b1;
        check(e_fetch, "R1 fetch after release");
    endtask

    task automatic t_load();
        opcode = 6'b100011;
        step(e_fetch, "R2 load fetch");
        step(e_dec,   "R3 load decode");
        step(e_addr,  "R4 load address");
        step(e_mrd,   "R4 load memory read");
        step(e_ldwb,  "R4 load write-back");
        check(e_fetch, "R4 load returns to fetch");
    endtask

    task automatic t_store();
        opcode = 6'b101011;
        step(e_fetch, "R2 store fetch");
        step(e_dec,   "R3 store decode");
        step(e_addr,  "R5 store address");
        step(e_mwr,   "R5 store memory write");
        check(e_fetch, "R5 store returns to fetch");
    endtask

    task automatic t_regop();
        opcode = 6'b000000;
        step(e_fetch, "R2 regop fetch");
        step(e_dec,   "R3 regop decode");
        step(e_exec,  "R6 regop execute");
        step(e_rdone, "R6 regop completion");
        check(e_fetch, "R6 regop returns to fetch");
    endtask

    task automatic t_branch();
        opcode = 6'b000100;
        step(e_fetch, "R2 branch fetch");
        step(e_dec,   "R3 branch decode");
        step(e_br,    "R7 branch compare");
        check(e_fetch, "R7 branch returns to fetch");
    endtask

    task automatic t_jump();
        opcode = 6'b000010;
        step(e_fetch, "R2 jump fetch");
        step(e_dec,   "R3 jump decode");
        step(e_jmp,   "R8 jump update");
        check(e_fetch, "R8 jump returns to fetch");
    endtask

    task automatic t_unknown(input logic [5:0] op);
        opcode = op;
        step(e_fetch, "R9 unknown fetch");
        step(e_dec,   "R9 unknown decode no writes");
        check(e_fetch, "R9 unknown back to fetch");
    endtask

    task automatic t_ignore();
        opcode = 6'b000010;
        check(e_fetch, "R10 fetch with jump opcode");
        @(negedge clk);
        opcode = 6'b000000;
        step(e_dec,   "R10 decode sees regop");
        opcode = 6'b100011;
        step(e_exec,  "R10 execute ignores load opcode");
        opcode = 6'b000100;
        step(e_rdone, "R10 completion ignores branch opcode");
        check(e_fetch, "R10 regop ends normally");
        opcode = 6'b100011;
        step(e_fetch, "R10 load fetch");
        step(e_dec,   "R10 load decode");
        step(e_addr,  "R10 load address");
        opcode = 6'b101011;
        step(e_mrd,   "R10 memory read ignores store opcode");
        opcode = 6'b000010;
        step(e_ldwb,  "R10 write-back ignores jump opcode");
        check(e_fetch, "R10 load ends normally");
    endtask

    task automatic t_mid_reset();
        opcode = 6'b100011;
        step(e_fetch, "R1 load fetch before abort");
        step(e_dec,   "R1 load decode before abort");
        step(e_addr,  "R1 load address before abort");
        rst_n = 1'b0;
        check(e_zero, "R1 reset mid-load silences outputs");
        @(negedge clk);
        check(e_zero, "R1 still quiet in reset");
        rst_n = 1'b1;
        check(e_fetch, "R1 restart at fetch");
    endtask

    initial begin
        rst_n = 1'b0;
        opcode = '0;
        t_reset();
        t_load();
        t_store();
        t_regop();
        t_branch();
        t_jump();
        t_unknown(6'b111111);
        t_unknown(6'b001000);
        t_load();
        t_ignore();
        t_mid_reset();
        t_branch();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule